// File: doc/BRIEF.md
# AUX Request to I2C Bridge Controller

The block takes one auxiliary-channel request at a time (command, address, byte count and a write buffer) and carries it out on one of two back-end ports. Native commands move bytes one by one to a local register port with a 20-bit address space. The address starts at the request address and increments after each byte. I2C-over-AUX commands are turned into byte-level operations for an external I2C master: start with address and direction, write a byte, read a byte, and stop.

Commands that carry the middle-of-transaction flag leave the I2C bus open after they succeed. A later flagged command with the same address and the same command continues that open transfer without a new start. A change of address or command closes the transfer and opens a new one. Every request ends with one reply pulse. Read bytes are streamed out with their index as they arrive.

Top module: `aux_i2c_bridge`

## Requirements
- R1: A native command (req_cmd = 4'b1000 write, 4'b1001 read) makes one register access per byte. The accesses go to req_addr, req_addr+1, and so on, wrapping within 20 bits. Write byte k is req_wdata[8k+7:8k].
- R2: A native command stops at the first access that returns reg_fail and replies rsp_code = 2'b01 (NACK). If every byte succeeds it replies 2'b00 (ACK).
- R3: A plain I2C command (4'b0000 write, 4'b0001 read) first issues a stop if a transfer is open. It then issues a start with req_addr[6:0] and the command direction. A start that returns i2c_nack replies rsp_i2c = 2'b01 and issues no stop.
- R4: A plain I2C command that started moves all bytes and always ends with a stop. A byte that returns i2c_nack ends the data phase and sets rsp_i2c = 2'b01. Otherwise rsp_i2c is 2'b00.
- R5: A flagged command (4'b0100 write, 4'b0101 read) issues a start when no transfer is open. If a transfer is open and both address and command match the previous flagged command, it issues neither stop nor start.
- R6: A flagged command that finds a transfer open, but with a different address or command than the previous flagged command, issues a stop and then a new start.
- R7: A flagged command issues no stop on success. A byte NACK makes it issue a stop and reply rsp_i2c = 2'b01. A refused start also replies rsp_i2c = 2'b01.
- R8: Any other command code (req_cmd[1] set, or both req_cmd[3] and req_cmd[2] set) replies rsp_code = 2'b01 with no register or I2C activity.
- R9: req_ready is high only while idle. Each accepted request gives exactly one single-cycle rsp_valid. The two back-end ports are never active together.
- R10: Each successfully read byte is presented once on rd_data with rd_valid, and rd_idx counts from 0 within the request.
- R11: Synchronous reset marks the I2C transfer closed and clears the remembered address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register address or I2C address (low 7 bits) |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, byte k in bits 8k+7:8k |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_code | output | 2 | 00 ACK, 01 NACK |
| rsp_i2c | output | 2 | 00 ACK, 01 I2C NACK |
| rd_valid | output | 1 | Read byte strobe |
| rd_idx | output | 4 | Index of the read byte |
| rd_data | output | 8 | Read byte |
| reg_req | output | 1 | Register access held until reg_done |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 20 | Register address |
| reg_wdata | output | 8 | Register write byte |
| reg_done | input | 1 | Register access complete |
| reg_fail | input | 1 | Register access rejected |
| reg_rdata | input | 8 | Register read byte |
| i2c_valid | output | 1 | I2C operation held until i2c_done |
| i2c_op | output | 2 | 00 start, 01 write byte, 10 read byte, 11 stop |
| i2c_addr | output | 7 | I2C target address for start |
| i2c_rnw | output | 1 | Direction for start, 1 = read |
| i2c_wdata | output | 8 | I2C write byte |
| i2c_done | input | 1 | I2C operation complete |
| i2c_nack | input | 1 | I2C operation not acknowledged |
| i2c_rdata | input | 8 | I2C read byte |

## Verification
The bench walks a sequence of flagged commands that continue, change command, change address, lose a byte and lose a start, and counts starts and stops for each one. A design that compared only the address would miss the read/write change and skip a restart. One that cleared the open state on a refused start in the wrong place would send a stray stop or omit a needed one. Native runs cross a rejecting address, so stopping late shows up as extra accesses, and a run that ends at the top of the address space checks the increment. A reset between two identical flagged commands catches open state that survives reset and suppresses the second start.

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge #(
  parameter int AW = 20,
  parameter int MAXLEN = 16,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int IW = $clog2(MAXLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [AW-1:0]     req_addr,
  input  logic [LW-1:0]     req_len,
  input  logic [MAXLEN*8-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [1:0]        rsp_i2c,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic              reg_req,
  output logic              reg_we,
  output logic [AW-1:0]     reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_done,
  input  logic              reg_fail,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_valid,
  output logic [1:0]        i2c_op,
  output logic [6:0]        i2c_addr,
  output logic              i2c_rnw,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_NAT, S_PSTOP, S_START, S_DATA, S_ESTOP, S_REPLY} st_t;

  st_t                 st;
  logic [3:0]          cmd, last_cmd;
  logic [AW-1:0]       addr, last_addr;
  logic [LW-1:0]       len;
  logic [MAXLEN*8-1:0] wbuf;
  logic [IW-1:0]       idx;
  logic [1:0]          code, i2cc;
  logic                open;

  wire is_read   = cmd[0];
  wire valid_cmd = !cmd[1] && !(cmd[3] && cmd[2]);
  wire last_byte = ({{(LW-IW){1'b0}}, idx} == len - LW'(1));
  wire [7:0] wbyte = wbuf[idx*8 +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      open      <= 1'b0;
      last_addr <= '0;
      last_cmd  <= '0;
      cmd       <= '0;
      addr      <= '0;
      len       <= '0;
      wbuf      <= '0;
      idx       <= '0;
      code      <= '0;
      i2cc      <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cmd  <= req_cmd;
          addr <= req_addr;
          len  <= req_len;
          wbuf <= req_wdata;
          idx  <= '0;
          code <= 2'b00;
          i2cc <= 2'b00;
          st   <= S_DISP;
        end
        S_DISP: begin
          if (!valid_cmd) begin
            code <= 2'b01;
            st   <= S_REPLY;
          end else if (cmd[3]) st <= S_NAT;
          else if (!cmd[2]) st <= open ? S_PSTOP : S_START;
          else if (!open) st <= S_START;
          else if (addr != last_addr || cmd != last_cmd) st <= S_PSTOP;
          else st <= S_DATA;
        end
        S_NAT: if (reg_done) begin
          if (reg_fail) begin
            code <= 2'b01;
            st   <= S_REPLY;
          end else if (last_byte) st <= S_REPLY;
          else idx <= idx + IW'(1);
        end
        S_PSTOP: if (i2c_done) begin
          open <= 1'b0;
          st   <= S_START;
        end
        S_START: if (i2c_done) begin
          if (i2c_nack) begin
            i2cc <= 2'b01;
            st   <= S_REPLY;
          end else begin
            open <= 1'b1;
            if (cmd[2]) begin
              last_addr <= addr;
              last_cmd  <= cmd;
            end
            st <= S_DATA;
          end
        end
        S_DATA: if (i2c_done) begin
          if (i2c_nack) begin
            i2cc <= 2'b01;
            st   <= S_ESTOP;
          end else if (last_byte) st <= cmd[2] ? S_REPLY : S_ESTOP;
          else idx <= idx + IW'(1);
        end
        S_ESTOP: if (i2c_done) begin
          open <= 1'b0;
          st   <= S_REPLY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_REPLY);
  assign rsp_code  = code;
  assign rsp_i2c   = i2cc;

  assign reg_req   = (st == S_NAT);
  assign reg_we    = !is_read;
  assign reg_addr  = addr + AW'(idx);
  assign reg_wdata = wbyte;

  assign i2c_valid = (st == S_PSTOP) || (st == S_START) || (st == S_DATA) || (st == S_ESTOP);
  assign i2c_op    = (st == S_START) ? 2'b00 : (st == S_DATA) ? (is_read ? 2'b10 : 2'b01) : 2'b11;
  assign i2c_addr  = addr[6:0];
  assign i2c_rnw   = is_read;
  assign i2c_wdata = wbyte;

  assign rd_valid = is_read && (((st == S_NAT) && reg_done && !reg_fail) ||
                                ((st == S_DATA) && i2c_done && !i2c_nack));
  assign rd_idx   = idx;
  assign rd_data  = (st == S_NAT) ? reg_rdata : i2c_rdata;

  p_single_port_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && i2c_valid));
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_reg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_done) |=> (reg_req && $stable(reg_addr)));
  p_reg_step_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_done && !reg_fail) |=> (!reg_req || reg_addr == $past(reg_addr) + AW'(1)));
  p_reg_fail_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_done && reg_fail) |=> (rsp_valid && rsp_code == 2'b01));
  p_i2c_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (i2c_valid && !i2c_done) |=> (i2c_valid && $stable(i2c_op)));
  p_bad_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_DISP && !valid_cmd) |=> (rsp_valid && rsp_code == 2'b01 && !reg_req && !i2c_valid));
  p_rd_idx_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ({{(LW-IW){1'b0}}, rd_idx} < len));

endmodule

// File: tb/sim_aux_i2c_bridge.sv
module sim_aux_i2c_bridge;
  localparam int AW = 20;
  localparam int MAXLEN = 16;
  localparam int NV = 19;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_valid, req_ready, rsp_valid, rd_valid;
  logic [3:0] req_cmd;
  logic [AW-1:0] req_addr;
  logic [4:0] req_len;
  logic [MAXLEN*8-1:0] req_wdata;
  logic [1:0] rsp_code, rsp_i2c, i2c_op;
  logic [3:0] rd_idx;
  logic [7:0] rd_data, reg_wdata, reg_rdata, i2c_wdata, i2c_rdata;
  logic reg_req, reg_we, reg_done, reg_fail;
  logic [AW-1:0] reg_addr;
  logic i2c_valid, i2c_rnw, i2c_done, i2c_nack;
  logic [6:0] i2c_addr;

  aux_i2c_bridge u0 (.*);

  // responder and monitor state, written only here
  int n_reg = 0, n_start = 0, n_stop = 0, n_rd = 0, n_rsp = 0, wd_bad = 0, rd_bad = 0, tx_bytes = 0;
  logic [AW-1:0] last_reg = '0;
  logic [3:0] last_idx = '0;
  logic [1:0] got_code = '0, got_i2c = '0;
  logic [3:0] cur_cmd = '0;
  logic [AW-1:0] cur_base = '0;

  always @(posedge clk) begin
    reg_done <= reg_req && !reg_done;
    i2c_done <= i2c_valid && !i2c_done;
    if (reg_req && !reg_done) begin
      n_reg <= n_reg + 1;
      last_reg <= reg_addr;
      reg_fail <= (reg_addr == 20'h00050);
      reg_rdata <= reg_addr[7:0] ^ 8'hA5;
      if (reg_we && reg_wdata != reg_addr[7:0]) wd_bad <= wd_bad + 1;
    end
    if (i2c_valid && !i2c_done) begin
      i2c_rdata <= 8'h3C;
      case (i2c_op)
        2'b00: begin n_start <= n_start + 1; tx_bytes <= 0; i2c_nack <= (i2c_addr == 7'h7F); end
        2'b11: begin n_stop <= n_stop + 1; i2c_nack <= 1'b0; end
        default: begin
          tx_bytes <= tx_bytes + 1;
          i2c_nack <= (i2c_addr == 7'h55) && (tx_bytes == 2);
        end
      endcase
    end
    if (rd_valid) begin
      n_rd <= n_rd + 1;
      last_idx <= rd_idx;
      if (rd_data != (cur_cmd[3] ? ((cur_base[7:0] + 8'(rd_idx)) ^ 8'hA5) : 8'h3C)) rd_bad <= rd_bad + 1;
    end
    if (rsp_valid) begin
      n_rsp <= n_rsp + 1;
      got_code <= rsp_code;
      got_i2c <= rsp_i2c;
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int d_reg, d_start, d_stop, d_rd;

  task automatic run(input logic [3:0] c, input logic [AW-1:0] a, input logic [4:0] l);
    int b_reg, b_start, b_stop, b_rd, b_rsp, n;
    @(negedge clk);
    cur_cmd = c;
    cur_base = a;
    req_cmd = c;
    req_addr = a;
    req_len = l;
    for (int k = 0; k < MAXLEN; k++) req_wdata[k*8 +: 8] = a[7:0] + 8'(k);
    b_reg = n_reg; b_start = n_start; b_stop = n_stop; b_rd = n_rd; b_rsp = n_rsp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy ready", int'(req_ready), 0);
    n = 0;
    while (n_rsp == b_rsp && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk("R9 reply timeout", 0, 1);
    d_reg = n_reg - b_reg; d_start = n_start - b_start; d_stop = n_stop - b_stop; d_rd = n_rd - b_rd;
  endtask

  // {cmd, addr, len, code, i2c, starts, stops, regops, reads}
  localparam logic [48:0] VEC [NV] = '{
    {4'b1000, 20'h00010, 5'd4, 2'd0, 2'd0, 3'd0, 3'd0, 5'd4, 5'd0},
    {4'b1001, 20'h00020, 5'd3, 2'd0, 2'd0, 3'd0, 3'd0, 5'd3, 5'd3},
    {4'b1000, 20'h0004E, 5'd4, 2'd1, 2'd0, 3'd0, 3'd0, 5'd3, 5'd0},
    {4'b0011, 20'h00001, 5'd1, 2'd1, 2'd0, 3'd0, 3'd0, 5'd0, 5'd0},
    {4'b1100, 20'h00001, 5'd1, 2'd1, 2'd0, 3'd0, 3'd0, 5'd0, 5'd0},
    {4'b0000, 20'h00021, 5'd2, 2'd0, 2'd0, 3'd1, 3'd1, 5'd0, 5'd0},
    {4'b0001, 20'h00022, 5'd3, 2'd0, 2'd0, 3'd1, 3'd1, 5'd0, 5'd3},
    {4'b0000, 20'h0007F, 5'd1, 2'd0, 2'd1, 3'd1, 3'd0, 5'd0, 5'd0},
    {4'b0100, 20'h00030, 5'd2, 2'd0, 2'd0, 3'd1, 3'd0, 5'd0, 5'd0},
    {4'b0100, 20'h00030, 5'd1, 2'd0, 2'd0, 3'd0, 3'd0, 5'd0, 5'd0},
    {4'b0101, 20'h00030, 5'd2, 2'd0, 2'd0, 3'd1, 3'd1, 5'd0, 5'd2},
    {4'b0101, 20'h00031, 5'd1, 2'd0, 2'd0, 3'd1, 3'd1, 5'd0, 5'd1},
    {4'b0000, 20'h00021, 5'd1, 2'd0, 2'd0, 3'd1, 3'd2, 5'd0, 5'd0},
    {4'b0100, 20'h00055, 5'd3, 2'd0, 2'd1, 3'd1, 3'd1, 5'd0, 5'd0},
    {4'b0100, 20'h00055, 5'd2, 2'd0, 2'd0, 3'd1, 3'd0, 5'd0, 5'd0},
    {4'b0100, 20'h0007F, 5'd1, 2'd0, 2'd1, 3'd1, 3'd1, 5'd0, 5'd0},
    {4'b0100, 20'h0007F, 5'd1, 2'd0, 2'd1, 3'd1, 3'd0, 5'd0, 5'd0},
    {4'b1000, 20'hFFFFE, 5'd2, 2'd0, 2'd0, 3'd0, 3'd0, 5'd2, 5'd0},
    {4'b1001, 20'h0004F, 5'd3, 2'd1, 2'd0, 3'd0, 3'd0, 5'd2, 5'd1}
  };

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] c;
    logic [AW-1:0] a;
    logic [4:0] l;
    string rc, rs;
    rst = 1'b1; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0; req_wdata = '0;
    reg_done = 1'b0; reg_fail = 1'b0; reg_rdata = '0;
    i2c_done = 1'b0; i2c_nack = 1'b0; i2c_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset ready", int'(req_ready), 1);
    chk("R9 reset rsp_valid", int'(rsp_valid), 0);
    chk("R9 reset ports idle", int'(reg_req | i2c_valid), 0);

    for (int v = 0; v < NV; v++) begin
      c = VEC[v][48:45]; a = VEC[v][44:25]; l = VEC[v][24:20];
      run(c, a, l);
      rc = !(!c[1] && !(c[3] && c[2])) ? "R8" : c[3] ? "R2" : c[2] ? "R7" : "R4";
      rs = c[3] ? "R8" : c[2] ? "R6" : "R3";
      chk({rc, " code"}, int'(got_code), int'(VEC[v][19:18]));
      chk({rc, " i2c reply"}, int'(got_i2c), int'(VEC[v][17:16]));
      chk({rs, " starts"}, d_start, int'(VEC[v][15:13]));
      chk({rs, " stops"}, d_stop, int'(VEC[v][12:10]));
      chk("R1 register accesses", d_reg, int'(VEC[v][9:5]));
      chk("R10 read bytes", d_rd, int'(VEC[v][4:0]));
      if (c[3] && !c[2] && VEC[v][19:18] == 2'd0) chk("R1 last address", int'(last_reg), int'(a + AW'(l) - AW'(1)));
    end

    // R10 / R1: longest native read
    run(4'b1001, 20'h00100, 5'd16);
    chk("R10 max reads", d_rd, 16);
    chk("R10 last index", int'(last_idx), 15);
    chk("R1 max last address", int'(last_reg), 32'h10F);

    // R5: continue with same address and command
    run(4'b0101, 20'h00044, 5'd1);
    chk("R5 first start", d_start, 1);
    run(4'b0101, 20'h00044, 5'd2);
    chk("R5 continue no start", d_start, 0);
    chk("R5 continue no stop", d_stop, 0);

    // R11: reset closes the open transfer
    run(4'b0100, 20'h00040, 5'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    run(4'b0100, 20'h00040, 5'd1);
    chk("R11 start after reset", d_start, 1);
    chk("R11 no stop after reset", d_stop, 0);

    chk("R1 write bytes", wd_bad, 0);
    chk("R10 read data", rd_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule